// File: doc/BRIEF.md
# Embedded Core Control and Interrupt Unit

This unit sits next to a small embedded processor core and gives a host a register window onto it. Through a simple 32-bit register bus the host can hard-reset the core, hold a launch address and start the core there, and see whether the core has halted or is running. It can also read whether the core is idle, read whether the post-reset memory scrubbing has finished, and swap words with the core through two mailboxes.

An interrupt section collects event lines from the core, including the halt event. These events are latched into a status register. Each line is enabled through separate mask-set and mask-clear strobe registers. A destination register routes each line either to the host interrupt output or to the core interrupt output.

The core, its memories and its DMA engine are not part of the unit. They appear only as status inputs and as control pulses. After every reset the scrubbing of both memories is modelled as a countdown of fixed length. Start requests made during that countdown are refused.

Top module: `core_ctl_unit`

## Requirements
- R1: After reset, every register reads 0: control, boot vector, mailboxes, mask, destination and status. Both interrupt outputs, `core_rst` and `core_start` are 0.
- R2: Writing word address 0 (control) with bit 0 set pulses `core_rst` high for exactly one cycle and clears the running flag (control bit 3). The halted flag (control bit 2), the boot vector and the mailboxes are kept. Control bits 0 and 1 always read 0.
- R3: Scrubbing status sits at address 5. Bit 0 (data memory) reads 1 for the first DMEM_SCRUB cycles after any reset, and bit 1 (instruction memory) reads 1 for the first IMEM_SCRUB cycles. "Any reset" means the reset pin or a hard-reset write. Scrubbing is done only when both bits read 0.
- R4: A control write with bit 1 set and bit 0 clear is a start request. If no scrub flag is set, `core_start` pulses for one cycle, `start_pc` takes the boot vector (address 1), running reads 1 and halted reads 0. During scrubbing the request is ignored.
- R5: A `core_halt` pulse sets halted (control bit 2), clears running, and sets interrupt status bit 4.
- R6: Writing ones to address 6 sets those mask bits. Writing ones to address 7 clears them, so writing all ones disables every line. Both addresses read back the mask.
- R7: Status (address 9) bits are set by `irq_evt` pulses. Writing ones to address 10 clears them. A bit that is set and cleared in the same cycle stays set.
- R8: `irq_host` is 1 exactly when some bit is set in status AND mask AND NOT destination (address 8). `irq_core` is 1 exactly when some bit is set in status AND mask AND destination.
- R9: Idle status is at address 4. Bit 0 reads 1 only when both `core_busy` and `ext_busy` are 0. Bits 1 and 2 mirror `core_busy` and `ext_busy`.
- R10: The mailboxes are at addresses 2 and 3 and appear on `mbox0` and `mbox1`. The core writes them through `core_mb_wr`, and `core_mb_sel` picks which one. If the host writes the same mailbox in the same cycle, the host value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| core_halt | input | 1 | Core halted pulse |
| core_busy | input | 1 | Core internal busy |
| ext_busy | input | 1 | Core external busy |
| irq_evt | input | NIRQ | Interrupt event pulses |
| core_mb_wr | input | 1 | Core mailbox write |
| core_mb_sel | input | 1 | Core mailbox select |
| core_mb_data | input | 32 | Core mailbox data |
| mbox0 | output | 32 | Mailbox 0 contents |
| mbox1 | output | 32 | Mailbox 1 contents |
| core_rst | output | 1 | One-cycle core hard-reset pulse |
| core_start | output | 1 | One-cycle core start pulse |
| start_pc | output | BOOT_W | Launch address captured at start |
| scrub_busy | output | 1 | Either memory still scrubbing |
| irq_host | output | 1 | Interrupt routed to host |
| irq_core | output | 1 | Interrupt routed to core |

## Verification
Faults in the latched status, the mask or the destination appear on `irq_host` or `irq_core` in the cycle after the write or event that exposes them. The status and mask registers also read back through the bus at once. A faulty scrub counter shows at a flag edge, one cycle early or late, and a start pulse appears or goes missing at the scrub boundary. A faulty run/halt state shows in control bits 2 and 3 right after a start, halt or hard-reset edge.

// File: rtl/core_ctl_unit.sv
module core_ctl_unit #(
  parameter int NIRQ       = 8,
  parameter int BOOT_W     = 16,
  parameter int DMEM_SCRUB = 6,
  parameter int IMEM_SCRUB = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [3:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              core_halt,
  input  logic              core_busy,
  input  logic              ext_busy,
  input  logic [NIRQ-1:0]   irq_evt,
  input  logic              core_mb_wr,
  input  logic              core_mb_sel,
  input  logic [31:0]       core_mb_data,
  output logic [31:0]       mbox0,
  output logic [31:0]       mbox1,
  output logic              core_rst,
  output logic              core_start,
  output logic [BOOT_W-1:0] start_pc,
  output logic              scrub_busy,
  output logic              irq_host,
  output logic              irq_core
);
  localparam int HALT_BIT  = 4;
  localparam int SCRUB_MAX = (DMEM_SCRUB > IMEM_SCRUB) ? DMEM_SCRUB : IMEM_SCRUB;
  localparam int CW        = $clog2(SCRUB_MAX + 1);

  logic [BOOT_W-1:0] boot_q;
  logic [NIRQ-1:0]   mask_q, dest_q, stat_q;
  logic [CW-1:0]     scrub_cnt;
  logic              halted_q, running_q;

  wire wr_ctl  = bus_wr && bus_addr == 4'd0;
  wire hrst_w  = wr_ctl && bus_wdata[0];
  wire scrub_d = scrub_cnt < CW'(DMEM_SCRUB);
  wire scrub_i = scrub_cnt < CW'(IMEM_SCRUB);
  wire go      = wr_ctl && bus_wdata[1] && !bus_wdata[0] && !scrub_d && !scrub_i;

  wire [NIRQ-1:0] halt_vec = NIRQ'(core_halt) << HALT_BIT;
  wire [NIRQ-1:0] set_vec  = irq_evt | halt_vec;
  wire [NIRQ-1:0] clr_vec  = (bus_wr && bus_addr == 4'd10) ? bus_wdata[NIRQ-1:0] : '0;
  wire [NIRQ-1:0] live     = stat_q & mask_q;

  assign scrub_busy = scrub_d | scrub_i;
  assign irq_host   = |(live & ~dest_q);
  assign irq_core   = |(live & dest_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot_q     <= '0;
      mask_q     <= '0;
      dest_q     <= '0;
      stat_q     <= '0;
      scrub_cnt  <= '0;
      halted_q   <= 1'b0;
      running_q  <= 1'b0;
      core_rst   <= 1'b0;
      core_start <= 1'b0;
      start_pc   <= '0;
      mbox0      <= '0;
      mbox1      <= '0;
    end else begin
      core_rst   <= hrst_w;
      core_start <= go;
      if (go) begin
        start_pc  <= boot_q;
        running_q <= 1'b1;
        halted_q  <= 1'b0;
      end
      if (core_halt) begin
        halted_q  <= 1'b1;
        running_q <= 1'b0;
      end
      if (hrst_w) begin
        running_q <= 1'b0;
        scrub_cnt <= '0;
      end else if (scrub_cnt < CW'(SCRUB_MAX)) begin
        scrub_cnt <= scrub_cnt + 1'b1;
      end
      if (core_mb_wr && !core_mb_sel) mbox0 <= core_mb_data;
      if (core_mb_wr &&  core_mb_sel) mbox1 <= core_mb_data;
      if (bus_wr) begin
        case (bus_addr)
          4'd1: boot_q <= bus_wdata[BOOT_W-1:0];
          4'd2: mbox0  <= bus_wdata;
          4'd3: mbox1  <= bus_wdata;
          4'd6: mask_q <= mask_q | bus_wdata[NIRQ-1:0];
          4'd7: mask_q <= mask_q & ~bus_wdata[NIRQ-1:0];
          4'd8: dest_q <= bus_wdata[NIRQ-1:0];
          default: ;
        endcase
      end
      stat_q <= (stat_q & ~clr_vec) | set_vec;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      4'd0:       bus_rdata = {28'd0, running_q, halted_q, 2'b00};
      4'd1:       bus_rdata = {{(32-BOOT_W){1'b0}}, boot_q};
      4'd2:       bus_rdata = mbox0;
      4'd3:       bus_rdata = mbox1;
      4'd4:       bus_rdata = {29'd0, ext_busy, core_busy, !(core_busy || ext_busy)};
      4'd5:       bus_rdata = {30'd0, scrub_i, scrub_d};
      4'd6, 4'd7: bus_rdata = {{(32-NIRQ){1'b0}}, mask_q};
      4'd8:       bus_rdata = {{(32-NIRQ){1'b0}}, dest_q};
      4'd9, 4'd10: bus_rdata = {{(32-NIRQ){1'b0}}, stat_q};
      default:    bus_rdata = '0;
    endcase
  end
endmodule

module core_ctl_unit_chk #(
  parameter int NIRQ = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_wr,
  input logic [3:0]      bus_addr,
  input logic [31:0]     bus_wdata,
  input logic            core_halt,
  input logic            core_rst,
  input logic            core_start,
  input logic            scrub_busy,
  input logic [NIRQ-1:0] stat,
  input logic [NIRQ-1:0] mask,
  input logic            irq_host,
  input logic            irq_core
);
  // R4
  start_after_scrub_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |-> !$past(scrub_busy));
  // R2
  rst_restarts_scrub_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst |-> scrub_busy);
  // R2
  rst_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst |=> !core_rst || $past(bus_wr && bus_addr == 4'd0 && bus_wdata[0]));
  // R5
  halt_sets_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_halt |=> stat[4]);
  // R6
  mask_clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 4'd7 && bus_wdata[NIRQ-1:0] == '1) |=> mask == '0);
  // R8
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq_host && !irq_core);
endmodule

bind core_ctl_unit core_ctl_unit_chk #(.NIRQ(NIRQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .core_halt(core_halt), .core_rst(core_rst),
  .core_start(core_start), .scrub_busy(scrub_busy), .stat(stat_q),
  .mask(mask_q), .irq_host(irq_host), .irq_core(irq_core)
);

// File: tb/tb_core_ctl_unit.sv
`timescale 1ns/1ps
module tb_core_ctl_unit;
  localparam int NIRQ = 8, BOOT_W = 16, DS = 6, IS = 10;

  logic clk = 0, rst_n = 0;
  logic bus_wr = 0;
  logic [3:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic core_halt = 0, core_busy = 0, ext_busy = 0;
  logic [NIRQ-1:0] irq_evt = 0;
  logic core_mb_wr = 0, core_mb_sel = 0;
  logic [31:0] core_mb_data = 0, mbox0, mbox1;
  logic core_rst, core_start, scrub_busy, irq_host, irq_core;
  logic [BOOT_W-1:0] start_pc;

  int checks = 0, fails = 0;
  logic [NIRQ-1:0] m_stat = 0, m_mask = 0, m_dest = 0;

  always #2.5 clk = ~clk;

  core_ctl_unit #(.NIRQ(NIRQ), .BOOT_W(BOOT_W), .DMEM_SCRUB(DS), .IMEM_SCRUB(IS)) dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a; #0.5; d = bus_rdata;
  endtask

  task automatic evt(input logic [NIRQ-1:0] v);
    @(negedge clk); irq_evt = v;
    @(negedge clk); irq_evt = 0;
  endtask

  function automatic logic exp_host(input logic [NIRQ-1:0] s, m, d);
    return |(s & m & ~d);
  endfunction
  function automatic logic exp_core(input logic [NIRQ-1:0] s, m, d);
    return |(s & m & d);
  endfunction

  task automatic chk_irq(input string req);
    logic [31:0] r;
    chk({req, " irq_host"}, 32'(irq_host), 32'(exp_host(m_stat, m_mask, m_dest)));
    chk({req, " irq_core"}, 32'(irq_core), 32'(exp_core(m_stat, m_mask, m_dest)));
    rd(4'd9, r);  chk({req, " stat"}, r, 32'(m_stat));
    rd(4'd6, r);  chk({req, " mask"}, r, 32'(m_mask));
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog act=hung exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'h5eed_0042));
    #12 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(4'd0, r); chk("R1 ctrl", r, 0);
    rd(4'd1, r); chk("R1 boot", r, 0);
    rd(4'd9, r); chk("R1 stat", r, 0);
    rd(4'd6, r); chk("R1 mask", r, 0);
    chk("R1 outs", {mbox0[0], mbox1[0], irq_host, irq_core, core_rst, core_start}, 0);

    // R9 idle
    core_busy = 0; ext_busy = 0; rd(4'd4, r); chk("R9 idle both0", r, 32'h1);
    core_busy = 1; rd(4'd4, r); chk("R9 core busy", r, 32'h2);
    core_busy = 0; ext_busy = 1; rd(4'd4, r); chk("R9 ext busy", r, 32'h4);
    ext_busy = 0;

    // wait out power-on scrub, set boot vector
    repeat (IS + 2) @(negedge clk);
    rd(4'd5, r); chk("R3 done after reset", r, 0);
    wr(4'd1, 32'h0000_1a2c);

    // R2 hard reset: one pulse, scrub restarts
    wr(4'd0, 32'h1);
    chk("R2 core_rst pulse", 32'(core_rst), 1);
    rd(4'd5, r); chk("R3 both scrubbing", r, 32'h3);
    // R4 start ignored during scrub (cnt = 1 at its edge)
    wr(4'd0, 32'h2);
    chk("R2 core_rst one cycle", 32'(core_rst), 0);
    chk("R4 start ignored while scrubbing", 32'(core_start), 0);
    rd(4'd0, r); chk("R4 not running", r, 0);
    rd(4'd1, r); chk("R2 boot kept", r, 32'h1a2c);
    // cnt now 2; reach DS-1 then DS
    repeat (DS - 3) @(negedge clk);
    rd(4'd5, r); chk("R3 dmem still busy", r, 32'h3);
    @(negedge clk);
    rd(4'd5, r); chk("R3 dmem done imem busy", r, 32'h2);
    repeat (IS - DS - 1) @(negedge clk);
    rd(4'd5, r); chk("R3 imem last busy", r, 32'h2);
    @(negedge clk);
    rd(4'd5, r); chk("R3 scrub done", r, 0);

    // R4 start accepted
    wr(4'd0, 32'h2);
    chk("R4 core_start", 32'(core_start), 1);
    chk("R4 start_pc", 32'(start_pc), 32'h1a2c);
    rd(4'd0, r); chk("R4 running", r, 32'h8);
    @(negedge clk);
    chk("R4 start one cycle", 32'(core_start), 0);

    // R5 halt
    @(negedge clk); core_halt = 1;
    @(negedge clk); core_halt = 0;
    m_stat[4] = 1;
    rd(4'd0, r); chk("R5 halted", r, 32'h4);
    rd(4'd9, r); chk("R5 stat bit4", r, 32'h10);
    // R2 hard reset keeps halted
    wr(4'd0, 32'h1);
    rd(4'd0, r); chk("R2 halted kept", r, 32'h4);

    // R7 set and clear same cycle -> set
    wr(4'd10, 32'hff); m_stat = 0;
    @(negedge clk); irq_evt = 8'h10; bus_wr = 1; bus_addr = 4'd10; bus_wdata = 32'h10;
    @(negedge clk); irq_evt = 0; bus_wr = 0;
    m_stat = 8'h10;
    rd(4'd9, r); chk("R7 set wins", r, 32'h10);

    // R10 mailboxes
    wr(4'd2, 32'hdead_beef);
    chk("R10 mbox0 host", mbox0, 32'hdead_beef);
    @(negedge clk); core_mb_wr = 1; core_mb_sel = 1; core_mb_data = 32'h1234_5678;
    @(negedge clk); core_mb_wr = 0;
    rd(4'd3, r); chk("R10 mbox1 core write", r, 32'h1234_5678);
    @(negedge clk); core_mb_wr = 1; core_mb_sel = 0; core_mb_data = 32'h1111_1111;
    bus_wr = 1; bus_addr = 4'd2; bus_wdata = 32'h2222_2222;
    @(negedge clk); core_mb_wr = 0; bus_wr = 0;
    chk("R10 host wins", mbox0, 32'h2222_2222);

    // R6 / R7 / R8 random mix
    for (int i = 0; i < 60; i++) begin
      logic [NIRQ-1:0] v;
      v = NIRQ'($urandom);
      case ($urandom % 5)
        0: begin evt(v); m_stat |= v; end
        1: begin wr(4'd6, 32'(v)); m_mask |= v; end
        2: begin wr(4'd7, 32'(v)); m_mask &= ~v; end
        3: begin wr(4'd10, 32'(v)); m_stat &= ~v; end
        default: begin wr(4'd8, 32'(v)); m_dest = v; end
      endcase
      chk_irq("R8 R6 R7 random");
    end

    // R6 all-ones clear
    wr(4'd6, 32'hff); m_mask = 8'hff;
    evt(8'h81); m_stat |= 8'h81;
    chk_irq("R8 all enabled");
    wr(4'd7, 32'hffff_ffff); m_mask = 0;
    chk_irq("R6 clear all");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule